// File: doc/BRIEF.md
# Sign-Magnitude Offset Trim Code Bank

This block holds one offset-trim code per channel and writes them over a narrow shared address bus. When external addressing is selected, the bus carries two things in turn: first a channel number, then a trim magnitude. A single strobe separates them. The address is captured when the strobe rises. The magnitude and a separate sign input are stored into that channel's code when the strobe falls. All inputs are sampled on the system clock, so strobe edges are seen as level changes between two clock samples.

The same bus also serves as an output. When internal addressing is selected, the block drives the hit-channel encoder address onto the bus and raises the bus output enable. The chosen address, either the external latched one or the internal encoder one, is decoded into a set of channel-select lines. Exactly one of those lines is high at all times.

Each stored code is in sign-magnitude form and is not symmetric. A positive code uses every magnitude bit. A negative code uses only the lower magnitude bits, because the sink side has one weight fewer than the source side. For checking, the block also presents every code as a signed value in trim steps.

Top module: `offset_trim_bank`

## Requirements
- R1: While the strobe is low, the address latch follows the bus each clock. While the strobe is high, the latch holds. With external addressing, `chan_sel` shows the latched channel one clock after the latch updates.
- R2: A strobe fall (strobe sampled low after being sampled high) with external addressing stores {sign_in, bus_in} into the latched channel. The code field layout is bit 5 = sign and bits 4:0 = magnitude. The code is visible on `codes` after that clock edge. `chan_sel` still points at the written channel in the cycle that follows.
- R3: A code with sign 0 reads on `steps` as +magnitude, from 0 to +31.
- R4: A code with sign 1 reads on `steps` as minus magnitude bits 3:0, from 0 to -15. Magnitude bit 4 is ignored for this value but is still kept in the stored code.
- R5: A synchronous master reset clears every stored code to zero and sets `chan_sel` to line 0.
- R6: With internal addressing (`sel_ext`=0), one clock later `bus_oe` is 1, `bus_out` equals `enc_addr`, and `chan_sel` selects `enc_addr`. Strobe activity stores nothing. With external addressing, `bus_oe` is 0.
- R7: `chan_sel` has exactly one bit set out of 2**ADDR_W lines.
- R8: A strobe write whose latched address is at or above the channel count changes no stored code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high master reset |
| sel_ext | input | 1 | 1 = external address from the bus, 0 = internal encoder address |
| strobe | input | 1 | Address-on-rise, data-on-fall strobe |
| sign_in | input | 1 | Sign of the code being written (1 = negative) |
| bus_in | input | ADDR_W | Shared bus value seen at the pads |
| enc_addr | input | ADDR_W | Internal hit-channel encoder address |
| bus_out | output | ADDR_W | Value driven onto the bus in internal mode |
| bus_oe | output | 1 | Bus output enable |
| chan_sel | output | 2**ADDR_W | One-hot channel selects |
| codes | output | CHANNELS*(MAG_W+1) | Stored codes, channel 0 in the low bits |
| steps | output | CHANNELS*(MAG_W+2) | Signed trim value per channel, two's complement |

## Verification
The hardest case to produce is a negative write whose top magnitude bit is set. In that case the stored code and the signed value disagree on purpose. The stimulus writes magnitude 31 with a negative sign and checks both outputs. It also writes magnitude 16 with a negative sign, so that bit 4 is the only magnitude bit set.

Writes that must have no effect are produced by three routes:
- a write to an out-of-range address;
- full strobe cycles under internal addressing;
- a master reset after the bank has been filled.

Each is followed by a comparison of the whole code vector against a snapshot taken just before.

// File: rtl/trim_pkg.sv
package trim_pkg;
  localparam int DEF_ADDR_W   = 5;
  localparam int DEF_MAG_W    = 5;
  localparam int DEF_CHANNELS = 16;

  typedef enum logic {
    BUS_LISTEN = 1'b0,
    BUS_DRIVE  = 1'b1
  } bus_dir_e;
endpackage

// File: rtl/trim_addr_path.sv
module trim_addr_path
  import trim_pkg::*;
#(
  parameter int ADDR_W   = DEF_ADDR_W,
  parameter int CHANNELS = DEF_CHANNELS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel_ext,
  input  logic                 strobe,
  input  logic [ADDR_W-1:0]    bus_in,
  input  logic [ADDR_W-1:0]    enc_addr,
  output logic [ADDR_W-1:0]    bus_out,
  output logic                 bus_oe,
  output logic [2**ADDR_W-1:0] chan_sel,
  output logic                 wr_en,
  output logic [ADDR_W-1:0]    wr_addr
);
  localparam int LINES = 2**ADDR_W;
  localparam logic [ADDR_W:0] CH_LIMIT = (ADDR_W+1)'(CHANNELS);

  logic              strobe_q;
  logic [ADDR_W-1:0] addr_lat;
  logic [ADDR_W-1:0] chosen;
  bus_dir_e          dir;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      addr_lat <= '0;
    end else begin
      strobe_q <= strobe;
      if (!strobe) addr_lat <= bus_in;
    end
  end

  assign chosen  = sel_ext ? addr_lat : enc_addr;
  assign dir     = sel_ext ? BUS_LISTEN : BUS_DRIVE;
  assign wr_addr = addr_lat;
  assign wr_en   = sel_ext && strobe_q && !strobe && ({1'b0, addr_lat} < CH_LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_sel <= LINES'(1);
      bus_out  <= '0;
      bus_oe   <= 1'b0;
    end else begin
      chan_sel <= LINES'(1) << chosen;
      bus_out  <= enc_addr;
      bus_oe   <= (dir == BUS_DRIVE);
    end
  end

  a_r7_one_line: assert property (@(posedge clk) disable iff (rst)
    $countones(chan_sel) == 1);

  a_r1_latch_holds: assert property (@(posedge clk) disable iff (rst)
    strobe |=> $stable(addr_lat));

  a_r6_drive_internal: assert property (@(posedge clk) disable iff (rst)
    !sel_ext |=> bus_oe && (bus_out == $past(enc_addr)));
endmodule

// File: rtl/trim_code_store.sv
module trim_code_store
  import trim_pkg::*;
#(
  parameter int ADDR_W   = DEF_ADDR_W,
  parameter int MAG_W    = DEF_MAG_W,
  parameter int CHANNELS = DEF_CHANNELS
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic                            wr_sign,
  input  logic [MAG_W-1:0]                wr_mag,
  output logic [CHANNELS*(MAG_W+1)-1:0]   codes
);
  localparam int CODE_W = MAG_W + 1;

  logic [CODE_W-1:0] bank [CHANNELS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CHANNELS; i++) bank[i] <= '0;
    end else if (wr_en) begin
      bank[wr_addr] <= {wr_sign, wr_mag};
    end
  end

  for (genvar g = 0; g < CHANNELS; g++) begin : g_flat
    assign codes[g*CODE_W +: CODE_W] = bank[g];
  end

  a_r5_cleared: assert property (@(posedge clk)
    rst |=> (codes == '0));

  a_r2_written: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> codes[$past(wr_addr)*CODE_W +: CODE_W] == {$past(wr_sign), $past(wr_mag)});
endmodule

// File: rtl/trim_step_map.sv
module trim_step_map
  import trim_pkg::*;
#(
  parameter int MAG_W    = DEF_MAG_W,
  parameter int CHANNELS = DEF_CHANNELS
) (
  input  logic [CHANNELS*(MAG_W+1)-1:0] codes,
  output logic [CHANNELS*(MAG_W+2)-1:0] steps
);
  localparam int CODE_W = MAG_W + 1;
  localparam int STEP_W = MAG_W + 2;
  localparam int NEG_W  = MAG_W - 1;

  for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
    logic [CODE_W-1:0]        code;
    logic signed [STEP_W-1:0] val;

    assign code = codes[g*CODE_W +: CODE_W];

    always_comb begin
      if (code[MAG_W]) val = -STEP_W'(code[NEG_W-1:0]);
      else             val = STEP_W'(code[MAG_W-1:0]);
    end

    assign steps[g*STEP_W +: STEP_W] = val;

    always_comb begin
      if (!$isunknown(code) && code[MAG_W])
        a_r4_sink_range: assert (val <= 0 && val > -(2**NEG_W));
    end
  end
endmodule

// File: rtl/offset_trim_bank.sv
module offset_trim_bank
  import trim_pkg::*;
#(
  parameter int ADDR_W   = DEF_ADDR_W,
  parameter int MAG_W    = DEF_MAG_W,
  parameter int CHANNELS = DEF_CHANNELS
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            sel_ext,
  input  logic                            strobe,
  input  logic                            sign_in,
  input  logic [ADDR_W-1:0]               bus_in,
  input  logic [ADDR_W-1:0]               enc_addr,
  output logic [ADDR_W-1:0]               bus_out,
  output logic                            bus_oe,
  output logic [2**ADDR_W-1:0]            chan_sel,
  output logic [CHANNELS*(MAG_W+1)-1:0]   codes,
  output logic [CHANNELS*(MAG_W+2)-1:0]   steps
);
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;

  trim_addr_path #(.ADDR_W(ADDR_W), .CHANNELS(CHANNELS)) u_addr (
    .clk(clk), .rst(rst), .sel_ext(sel_ext), .strobe(strobe),
    .bus_in(bus_in), .enc_addr(enc_addr), .bus_out(bus_out),
    .bus_oe(bus_oe), .chan_sel(chan_sel), .wr_en(wr_en), .wr_addr(wr_addr)
  );

  trim_code_store #(.ADDR_W(ADDR_W), .MAG_W(MAG_W), .CHANNELS(CHANNELS)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_sign(sign_in), .wr_mag(bus_in[MAG_W-1:0]), .codes(codes)
  );

  trim_step_map #(.MAG_W(MAG_W), .CHANNELS(CHANNELS)) u_map (
    .codes(codes), .steps(steps)
  );
endmodule

// File: tb/test_offset_trim_bank.sv
module test_offset_trim_bank;
  localparam int AW = 5, MW = 5, NCH = 16, CW = 6, SW = 7, NV = 8;

  logic clk = 1'b0, rst = 1'b1, sel_ext = 1'b1, strobe = 1'b0, sign_in = 1'b0;
  logic [AW-1:0] bus_in = '0, enc_addr = '0, bus_out;
  logic bus_oe;
  logic [2**AW-1:0] chan_sel;
  logic [NCH*CW-1:0] codes, snap;
  logic [NCH*SW-1:0] steps;
  int checks = 0, errors = 0;
  bit done = 0;

  // {channel, sign, magnitude, expected signed step}
  localparam logic [17:0] VEC [NV] = '{
    {5'd0,  1'b0, 5'd31, 7'h1F},
    {5'd1,  1'b0, 5'd0,  7'h00},
    {5'd2,  1'b1, 5'd15, 7'h71},
    {5'd3,  1'b1, 5'd31, 7'h71},
    {5'd4,  1'b1, 5'd16, 7'h00},
    {5'd5,  1'b0, 5'd16, 7'h10},
    {5'd15, 1'b1, 5'd5,  7'h7B},
    {5'd7,  1'b0, 5'd10, 7'h0A}
  };

  always #4 clk = ~clk;

  offset_trim_bank i_offset_trim_bank (
    .clk(clk), .rst(rst), .sel_ext(sel_ext), .strobe(strobe), .sign_in(sign_in),
    .bus_in(bus_in), .enc_addr(enc_addr), .bus_out(bus_out), .bus_oe(bus_oe),
    .chan_sel(chan_sel), .codes(codes), .steps(steps)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe_write(input logic [AW-1:0] ch, input logic sg,
                              input logic [AW-1:0] mag, input bit sel_chk);
    @(negedge clk); bus_in = ch; strobe = 1'b0;
    @(negedge clk); strobe = 1'b1;
    @(negedge clk); bus_in = mag; sign_in = sg;
    if (sel_chk) chk("R1 latched select", chan_sel, 32'd1 << ch);
    @(negedge clk); strobe = 1'b0;
    @(negedge clk);
    if (sel_chk) chk("R2 select held after write", chan_sel, 32'd1 << ch);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R5 codes after reset", codes, '0);
    chk("R5 select after reset", chan_sel, 32'd1);
    rst = 1'b0;
    @(negedge clk);
    chk("R6 bus released in external mode", bus_oe, 1'b0);

    for (int i = 0; i < NV; i++) begin
      strobe_write(VEC[i][17:13], VEC[i][12], VEC[i][11:7], 1'b1);
      chk("R2 stored code", codes[VEC[i][17:13]*CW +: CW], {VEC[i][12], VEC[i][11:7]});
      chk(VEC[i][12] ? "R4 negative step" : "R3 positive step",
          steps[VEC[i][17:13]*SW +: SW], VEC[i][6:0]);
      chk("R7 one select line", $countones(chan_sel), 1);
    end

    snap = codes;
    strobe_write(5'd20, 1'b0, 5'd9, 1'b1);
    chk("R8 out-of-range write ignored", codes, snap);

    sel_ext = 1'b0; enc_addr = 5'd9;
    @(negedge clk);
    chk("R6 bus driven", bus_oe, 1'b1);
    chk("R6 bus value", bus_out, 5'd9);
    chk("R6 select follows encoder", chan_sel, 32'd1 << 9);
    chk("R7 one select line internal", $countones(chan_sel), 1);
    snap = codes;
    strobe_write(5'd1, 1'b0, 5'd3, 1'b0);
    chk("R6 internal mode write ignored", codes, snap);

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R5 master reset clears codes", codes, '0);
    chk("R5 reset steps zero", steps, '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule